// File: doc/BRIEF.md
# LPC Host Cycle Generator

This block is the master side of a Low Pin Count bus. It turns single requests from a control port into complete I/O or memory transactions on a 4-bit multiplexed LAD bus with an active-low frame strobe. Each transaction opens with a frame nibble and a cycle-type nibble, then sends the address and, on writes, the data byte. The block then turns the bus around and waits for the peripheral's handshake nibble. On reads it collects the returned byte. It finishes with a final turnaround and reports completion with a one-clock pulse.

A single select input chooses between memory and I/O transactions. The two kinds differ in their type code, in the length of the address field and so in their total length. The LAD pins are brought out as a separate output nibble, an output enable and an input nibble, so the tri-state buffer sits outside the block. The bus clock is the block's own clock. If the peripheral never completes the handshake, a fixed timeout ends the transaction with an abort pattern.

Top module: `lpc_cycle_master`

## Requirements
- R1: After reset and while idle, `lframe_n` is 1, `lad_oe` is 0, `done` is 0 and `state_code` is 0. Idle code 0 is the only state code the bench relies on.
- R2: When `req_rd` or `req_wr` is high while idle, the next clock is a frame clock: `lframe_n` is low for exactly that one clock and LAD drives 0000b. If both flags are high, the transaction is a read.
- R3: In the clock after the frame clock, `lframe_n` is high and LAD carries the type nibble {0, mem, write, 0}: 0000b for I/O read, 0010b for I/O write, 0100b for memory read and 0110b for memory write.
- R4: The address follows, most significant nibble first. An I/O transaction sends 4 nibbles taken from `req_addr[15:0]`. A memory transaction sends 8 nibbles taken from `req_addr[31:0]`.
- R5: On writes, the data byte follows the address as two nibbles, bits [3:0] first and then bits [7:4].
- R6: After the last host nibble, LAD drives 1111b for one clock and is then released (`lad_oe` 0). LAD stays released through the handshake, any read data and the two closing turnaround clocks.
- R7: During the handshake, an input of 0000b completes it. Any other input, including the wait codes 0101b and 0110b, adds one more handshake clock.
- R8: On reads, the two clocks after the handshake nibble carry data bits [3:0] and then bits [7:4]. The byte appears on `rd_data` when `done` pulses.
- R9: `done` is high for one clock, the clock after the last closing turnaround clock. From the frame clock up to that point, a transaction lasts 13 clocks for I/O, 17 for a memory write and 17 plus the number of wait nibbles for a memory read (21 with four waits).
- R10: If SYNC_LIMIT handshake clocks pass without 0000b, the block drives `lframe_n` low with LAD at 1111b for four clocks and then returns to idle. It does not pulse `done` and leaves `rd_data` unchanged.
- R11: Address, data, direction and select are sampled only in the clock a transaction starts. Changing them afterwards has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Start a read transaction |
| req_wr | input | 1 | Start a write transaction |
| req_mem | input | 1 | 1 selects a memory transaction, 0 an I/O transaction |
| req_addr | input | 32 | Transaction address |
| req_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-clock completion pulse |
| state_code | output | 5 | Current sequencer state code (0 is idle) |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_o | output | 4 | LAD nibble driven by the host |
| lad_oe | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD nibble seen on the bus |

## Verification
The hardest situation to reach from the ports is the timeout abort. It happens only when the peripheral keeps the handshake open for the full limit, and it must leave the read register unchanged. The bench's peripheral model drives wait codes for every handshake clock of one transaction. It then follows the four abort clocks nibble by nibble and confirms that no completion pulse appears. Wait insertion and non-standard handshake codes are covered by stretching a memory read to 21 clocks and by an I/O write that sees 1010b before its ready nibble.

// File: rtl/lpc_cyc_pkg.sv
package lpc_cyc_pkg;

    typedef enum logic [4:0] {
        ST_IDLE    = 5'd0,
        ST_START   = 5'd1,
        ST_CTYPE   = 5'd2,
        ST_ADDR    = 5'd3,
        ST_WDATA   = 5'd4,
        ST_TAR_DRV = 5'd5,
        ST_TAR_FLT = 5'd6,
        ST_SYNC    = 5'd7,
        ST_RDATA   = 5'd8,
        ST_TAR_END = 5'd9,
        ST_ABORT   = 5'd10
    } lpc_state_e;

    typedef struct packed {
        logic is_mem;
        logic is_wr;
    } lpc_ctl_t;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_READY = 4'h0;
    localparam logic [3:0] NIB_ONES  = 4'hF;

    function automatic logic [3:0] cyc_type_nib(input lpc_ctl_t ctl);
        return {1'b0, ctl.is_mem, ctl.is_wr, 1'b0};
    endfunction

endpackage

// File: rtl/lpc_addr_nibbler.sv
module lpc_addr_nibbler #(
    parameter int IO_NIBS  = 4,
    parameter int MEM_NIBS = 8,
    parameter int CNT_W    = 4
) (
    input  logic [4*MEM_NIBS-1:0] addr,
    input  logic                  is_mem,
    input  logic [CNT_W-1:0]      idx,
    output logic [3:0]            nib_o,
    output logic                  last_o
);
    logic [3:0]       nib_arr [MEM_NIBS];
    logic [CNT_W-1:0] n_last;
    logic [CNT_W-1:0] pos;

    for (genvar g = 0; g < MEM_NIBS; g++) begin : g_nib
        assign nib_arr[g] = addr[4*g +: 4];
    end

    assign n_last = is_mem ? CNT_W'(MEM_NIBS - 1) : CNT_W'(IO_NIBS - 1);
    assign last_o = (idx == n_last);
    assign pos    = n_last - idx;

    always_comb begin
        nib_o = 4'h0;
        for (int k = 0; k < MEM_NIBS; k++) begin
            if (pos == CNT_W'(k)) nib_o = nib_arr[k];
        end
    end
endmodule

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
    parameter int SYNC_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic [3:0] lad_i,
    output logic       ready_o,
    output logic       expire_o
);
    import lpc_cyc_pkg::*;
    localparam int TW = $clog2(SYNC_LIMIT + 1);

    logic [TW-1:0] wait_q;

    assign ready_o  = active && (lad_i == NIB_READY);
    assign expire_o = active && !ready_o && (wait_q == TW'(SYNC_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) wait_q <= '0;
        else                wait_q <= wait_q + 1'b1;
    end
endmodule

// File: rtl/lpc_rdata_capture.sv
module lpc_rdata_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_lo,
    input  logic       cap_hi,
    input  logic [3:0] nib,
    output logic [7:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= 8'h00;
        end else begin
            if (cap_lo) data_o[3:0] <= nib;
            if (cap_hi) data_o[7:4] <= nib;
        end
    end
endmodule

// File: rtl/lpc_cycle_master.sv
module lpc_cycle_master #(
    parameter int IO_NIBS    = 4,
    parameter int MEM_NIBS   = 8,
    parameter int SYNC_LIMIT = 8,
    parameter int ABORT_CLKS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_rd,
    input  logic                  req_wr,
    input  logic                  req_mem,
    input  logic [4*MEM_NIBS-1:0] req_addr,
    input  logic [7:0]            req_wdata,
    output logic [7:0]            rd_data,
    output logic                  done,
    output logic [4:0]            state_code,
    output logic                  lframe_n,
    output logic [3:0]            lad_o,
    output logic                  lad_oe,
    input  logic [3:0]            lad_i
);
    import lpc_cyc_pkg::*;

    localparam int ADDR_W  = 4 * MEM_NIBS;
    localparam int CNT_MAX = (MEM_NIBS > ABORT_CLKS) ? MEM_NIBS : ABORT_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    lpc_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    lpc_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              done_q;

    logic [3:0] addr_nib;
    logic       addr_last;
    logic       sync_ready;
    logic       sync_expire;

    lpc_addr_nibbler #(
        .IO_NIBS (IO_NIBS),
        .MEM_NIBS(MEM_NIBS),
        .CNT_W   (CNT_W)
    ) nib_i (
        .addr  (addr_q),
        .is_mem(ctl_q.is_mem),
        .idx   (cnt_q),
        .nib_o (addr_nib),
        .last_o(addr_last)
    );

    lpc_sync_timer #(
        .SYNC_LIMIT(SYNC_LIMIT)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == ST_SYNC),
        .lad_i   (lad_i),
        .ready_o (sync_ready),
        .expire_o(sync_expire)
    );

    lpc_rdata_capture cap_i (
        .clk   (clk),
        .rst   (rst),
        .cap_lo((state_q == ST_RDATA) && (cnt_q == '0)),
        .cap_hi((state_q == ST_RDATA) && (cnt_q == CNT_W'(1))),
        .nib   (lad_i),
        .data_o(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_rd || req_wr) begin
                        state_q      <= ST_START;
                        ctl_q.is_mem <= req_mem;
                        ctl_q.is_wr  <= !req_rd;
                        addr_q       <= req_addr;
                        wdata_q      <= req_wdata;
                    end
                end
                ST_START: state_q <= ST_CTYPE;
                ST_CTYPE: begin
                    state_q <= ST_ADDR;
                    cnt_q   <= '0;
                end
                ST_ADDR: begin
                    if (addr_last) begin
                        cnt_q   <= '0;
                        state_q <= ctl_q.is_wr ? ST_WDATA : ST_TAR_DRV;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_TAR_DRV;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TAR_DRV: state_q <= ST_TAR_FLT;
                ST_TAR_FLT: state_q <= ST_SYNC;
                ST_SYNC: begin
                    cnt_q <= '0;
                    if (sync_ready)       state_q <= ctl_q.is_wr ? ST_TAR_END : ST_RDATA;
                    else if (sync_expire) state_q <= ST_ABORT;
                end
                ST_RDATA: begin
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_TAR_END;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TAR_END: begin
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ABORT: begin
                    if (cnt_q == CNT_W'(ABORT_CLKS - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        lframe_n = !((state_q == ST_START) || (state_q == ST_ABORT));
        lad_oe   = 1'b0;
        lad_o    = NIB_ONES;
        case (state_q)
            ST_START:   begin lad_oe = 1'b1; lad_o = NIB_START;            end
            ST_CTYPE:   begin lad_oe = 1'b1; lad_o = cyc_type_nib(ctl_q);  end
            ST_ADDR:    begin lad_oe = 1'b1; lad_o = addr_nib;             end
            ST_WDATA:   begin
                lad_oe = 1'b1;
                lad_o  = cnt_q[0] ? wdata_q[7:4] : wdata_q[3:0];
            end
            ST_TAR_DRV: begin lad_oe = 1'b1; lad_o = NIB_ONES;             end
            ST_ABORT:   begin lad_oe = 1'b1; lad_o = NIB_ONES;             end
            default:    begin lad_oe = 1'b0; lad_o = NIB_ONES;             end
        endcase
    end

    assign done       = done_q;
    assign state_code = state_q;
endmodule

// File: rtl/lpc_cycle_master_chk.sv
module lpc_cycle_master_chk #(
    parameter int CNT_W      = 4,
    parameter int ABORT_CLKS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input lpc_cyc_pkg::lpc_state_e state_q,
    input logic [CNT_W-1:0]        cnt_q,
    input logic                    lframe_n,
    input logic [3:0]              lad_o,
    input logic                    lad_oe,
    input logic                    done,
    input logic [7:0]              rd_data
);
    import lpc_cyc_pkg::*;

    assert_start_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(lframe_n) && $past(state_q) == ST_IDLE) |-> (lad_oe && lad_o == 4'h0));

    assert_lframe_release_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CTYPE) |-> (lframe_n && $past(!lframe_n)));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAR_FLT) |-> (!lad_oe && $past(lad_oe) && $past(lad_o) == 4'hF));

    assert_sync_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SYNC) |-> ($past(state_q) == ST_TAR_FLT || $past(state_q) == ST_SYNC));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_source_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state_q) == ST_TAR_END));

    assert_abort_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ABORT && cnt_q == CNT_W'(ABORT_CLKS - 1)) |=>
        (state_q == ST_IDLE && lframe_n && !done));

    assert_abort_keeps_data_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ABORT) |-> $stable(rd_data));
endmodule

bind lpc_cycle_master lpc_cycle_master_chk #(
    .CNT_W     (CNT_W),
    .ABORT_CLKS(ABORT_CLKS)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .lframe_n(lframe_n),
    .lad_o   (lad_o),
    .lad_oe  (lad_oe),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/lpc_cycle_master_tb_top.sv
module lpc_cycle_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0, req_wr = 1'b0, req_mem = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        done;
    logic [4:0]  state_code;
    logic        lframe_n;
    logic [3:0]  lad_o;
    logic        lad_oe;
    logic [3:0]  lad_i = 4'hF;

    int n_checks = 0;
    int n_fail   = 0;
    int clk_cnt  = 0;

    lpc_cycle_master #(.SYNC_LIMIT(SYNC_LIMIT)) dut_i (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_mem(req_mem),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .state_code(state_code), .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe),
        .lad_i(lad_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Compare one bus clock at the current negedge, drive the peripheral nibble, advance.
    task automatic expect_clk(input logic lf, input logic oe, input logic [3:0] lad,
                              input logic [3:0] drive, input string req);
        check(lframe_n === lf && lad_oe === oe && (!oe || lad_o === lad) && done === 1'b0,
              req, "bus {done,lframe_n,oe,lad}",
              int'({done, lframe_n, lad_oe, lad_o}), int'({1'b0, lf, oe, lad}));
        clk_cnt++;
        lad_i = drive;
        @(negedge clk);
    endtask

    task automatic run_cycle(input bit mem, input bit rd, input bit wr,
                             input logic [31:0] addr, input logic [7:0] wd,
                             input int nwait, input logic [3:0] wcode,
                             input logic [7:0] rdat, input bit timeout, input int exp_len);
        int n = mem ? 8 : 4;
        bit is_wr = !rd;
        logic [7:0] prev = rd_data;
        req_mem = mem; req_rd = rd; req_wr = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        // R11: scramble request inputs once the transaction has started
        req_rd = 1'b0; req_wr = 1'b0; req_mem = !mem; req_addr = ~addr; req_wdata = ~wd;
        clk_cnt = 0;
        expect_clk(1'b0, 1'b1, 4'h0, 4'hF, "R2");
        expect_clk(1'b1, 1'b1, {1'b0, mem, is_wr, 1'b0}, 4'hF, "R3");
        for (int i = 0; i < n; i++) expect_clk(1'b1, 1'b1, addr[4*(n-1-i) +: 4], 4'hF, "R4/R11");
        if (is_wr) begin
            expect_clk(1'b1, 1'b1, wd[3:0], 4'hF, "R5");
            expect_clk(1'b1, 1'b1, wd[7:4], 4'hF, "R5");
        end
        expect_clk(1'b1, 1'b1, 4'hF, 4'hF, "R6");
        expect_clk(1'b1, 1'b0, 4'h0, 4'hF, "R6");
        if (timeout) begin
            for (int w = 0; w < SYNC_LIMIT; w++) expect_clk(1'b1, 1'b0, 4'h0, wcode, "R7");
            for (int a = 0; a < 4; a++) expect_clk(1'b0, 1'b1, 4'hF, 4'hF, "R10");
            check(lframe_n === 1'b1 && lad_oe === 1'b0 && state_code === 5'd0,
                  "R10", "idle after abort", int'({lframe_n, lad_oe, state_code}), int'(7'b1000000));
            check(done === 1'b0, "R10", "no done after abort", int'(done), 0);
            check(rd_data === prev, "R10", "rd_data kept", int'(rd_data), int'(prev));
        end else begin
            for (int w = 0; w < nwait; w++) expect_clk(1'b1, 1'b0, 4'h0, wcode, "R7");
            expect_clk(1'b1, 1'b0, 4'h0, 4'h0, "R7");
            if (rd) begin
                expect_clk(1'b1, 1'b0, 4'h0, rdat[3:0], "R8");
                expect_clk(1'b1, 1'b0, 4'h0, rdat[7:4], "R8");
            end
            expect_clk(1'b1, 1'b0, 4'h0, 4'hF, "R6");
            expect_clk(1'b1, 1'b0, 4'h0, 4'hF, "R6");
            check(done === 1'b1, "R9", "done pulse", int'(done), 1);
            check(clk_cnt == exp_len, "R9", "cycle length", clk_cnt, exp_len);
            check(state_code === 5'd0 && lframe_n === 1'b1, "R1", "idle at done",
                  int'(state_code), 0);
            if (rd) check(rd_data === rdat, "R8", "read byte", int'(rd_data), int'(rdat));
        end
        @(negedge clk);
        check(done === 1'b0, "R9", "done one clock", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lframe_n === 1'b1 && lad_oe === 1'b0 && done === 1'b0 && state_code === 5'd0,
              "R1", "reset state", int'({lframe_n, lad_oe, done, state_code}), int'(8'b10000000));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(lframe_n === 1'b1 && lad_oe === 1'b0 && state_code === 5'd0,
              "R1", "idle without request", int'({lframe_n, lad_oe, state_code}), int'(7'b1000000));

        // I/O read, no waits
        run_cycle(1'b0, 1'b1, 1'b0, 32'h0000_1234, 8'h00, 0, 4'h5, 8'hA5, 1'b0, 13);
        // I/O write, a non-standard code counts as a wait (R7)
        run_cycle(1'b0, 1'b0, 1'b1, 32'hFFFF_BEEF, 8'h3C, 2, 4'hA, 8'h00, 1'b0, 15);
        // memory write
        run_cycle(1'b1, 1'b0, 1'b1, 32'h89AB_CDEF, 8'h71, 0, 4'h5, 8'h00, 1'b0, 17);
        // memory read with four wait nibbles
        run_cycle(1'b1, 1'b1, 1'b0, 32'h00C0_FFEE, 8'h00, 4, 4'h6, 8'h5E, 1'b0, 21);
        // both flags set: read wins (R2)
        run_cycle(1'b0, 1'b1, 1'b1, 32'h0000_0F0A, 8'h99, 1, 4'h5, 8'hC3, 1'b0, 14);
        // timeout abort after a read byte is held
        run_cycle(1'b0, 1'b1, 1'b0, 32'h0000_4321, 8'h00, 0, 4'h6, 8'h00, 1'b1, 0);
        // block recovers after abort
        run_cycle(1'b1, 1'b1, 1'b0, 32'h1357_9BDF, 8'h00, 0, 4'h5, 8'h2B, 1'b0, 17);

        finish_run();
    end
endmodule